// File: doc/BRIEF.md
# Dual-Output Level Interrupt Controller

The block collects a vector of level-sensitive interrupt lines and turns it into two request outputs for a processor. One is a normal interrupt request and the other a fast interrupt request. The same pending vector passes through two independent enable masks, and each output is the OR of the pending sources its own mask lets through. Prioritisation, vectoring and edge detection are not part of the block. Source 0 can also be raised by software through a latch, which gives a software-triggered interrupt.

Software reaches the block through a word-indexed register port. Enable masks are never written directly. Each mask has a word that sets bits and a word that clears bits. Software can read masked status, raw pending levels and the enable masks. An access to a word that does not support that direction returns zero on a read, changes nothing on a write, and raises a one-cycle error flag. Controllers can be chained: the request output of a secondary instance can drive one of the source lines of a primary instance, and the secondary's fast output is then left unused.

Top module: `dual_level_intc`

## Requirements
- R1: After reset both enable masks read as zero, the software latch is clear, and `irq_o` and `fiq_o` are low whatever the source lines do.
- R2: `irq_o` is high exactly when (pending AND IRQ mask) is non-zero, one clock after that condition is formed; the FIQ mask has no effect on it.
- R3: `fiq_o` is high exactly when (pending AND FIQ mask) is non-zero, one clock after that condition is formed; the IRQ mask has no effect on it.
- R4: A write to word 2 (IRQ) or word 10 (FIQ) ORs the write data into that mask. A write to word 3 (IRQ) or word 11 (FIQ) clears every mask bit that is 1 in the write data. Reads of word 2 and word 10 return the IRQ and FIQ masks.
- R5: Read word 0 returns pending AND IRQ mask, and read word 8 returns pending AND FIQ mask. Read words 1 and 9 both return the raw pending vector.
- R6: Sources are level-sensitive: a pending bit is 1 while its line is high and returns to 0 as soon as the line drops, with no memory of earlier pulses.
- R7: A write to word 4 with data bit 0 = 1 sets the software latch, and a write to word 5 with data bit 0 = 1 clears it. All other data bits are ignored. Pending bit 0 is source line 0 OR the latch, and read word 4 returns pending bit 0 in bit 0 with all other bits zero.
- R8: Reads of words 3, 5 and 11, and reads of unmapped words (6, 7, 12 to 15), return zero and raise the error flag.
- R9: Writes to words 0, 1, 8 and 9, and writes to unmapped words, leave both masks and the software latch unchanged and raise the error flag.
- R10: `bus_err_o` is high for one clock, in the cycle after the bad access, and stays low after a legal access. `bus_rvalid_o` and `bus_rdata_o` are valid in the cycle after a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NSRC (32) | Level-sensitive interrupt source lines |
| bus_sel_i | input | 1 | Register access request this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_word_i | input | 4 | Word index of the access |
| bus_wdata_i | input | NSRC (32) | Write data |
| bus_rdata_o | output | NSRC (32) | Read data, registered |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| bus_err_o | output | 1 | One-cycle pulse after a bad access |
| irq_o | output | 1 | Normal interrupt request, registered |
| fiq_o | output | 1 | Fast interrupt request, registered |

## Verification
A register access presented before clock edge k is acted on at edge k. Its read data, valid flag and error flag are therefore visible right after k, and the bench samples them on the falling edge that follows. A mask or latch change made at edge k reaches `irq_o`/`fiq_o` at edge k+1, while a source-line change reaches them at the first rising edge after it. The bench confirms an output is still unchanged one falling edge before the due edge and changed one falling edge after it. The error flag is sampled both in its due cycle and in the next idle cycle, so a stretched or missing pulse is caught.

// File: rtl/intc_pkg.sv
package intc_pkg;

  localparam int WORD_AW  = 4;
  localparam int NPATH    = 2;
  localparam int PATH_IRQ = 0;
  localparam int PATH_FIQ = 1;

  // Word indices of the register port
  localparam logic [WORD_AW-1:0] WRD_IRQ_STATUS = 4'd0;
  localparam logic [WORD_AW-1:0] WRD_IRQ_RAW    = 4'd1;
  localparam logic [WORD_AW-1:0] WRD_IRQ_EN_SET = 4'd2;
  localparam logic [WORD_AW-1:0] WRD_IRQ_EN_CLR = 4'd3;
  localparam logic [WORD_AW-1:0] WRD_SWI_SET    = 4'd4;
  localparam logic [WORD_AW-1:0] WRD_SWI_CLR    = 4'd5;
  localparam logic [WORD_AW-1:0] WRD_FIQ_STATUS = 4'd8;
  localparam logic [WORD_AW-1:0] WRD_FIQ_RAW    = 4'd9;
  localparam logic [WORD_AW-1:0] WRD_FIQ_EN_SET = 4'd10;
  localparam logic [WORD_AW-1:0] WRD_FIQ_EN_CLR = 4'd11;

  // Decoded events of one register access
  typedef struct packed {
    logic [NPATH-1:0] en_set;
    logic [NPATH-1:0] en_clr;
    logic             swi_set;
    logic             swi_clr;
    logic             rd_ok;
    logic             bad;
  } access_t;

  function automatic logic word_readable(input logic [WORD_AW-1:0] w);
    case (w)
      WRD_IRQ_STATUS, WRD_IRQ_RAW, WRD_IRQ_EN_SET, WRD_SWI_SET,
      WRD_FIQ_STATUS, WRD_FIQ_RAW, WRD_FIQ_EN_SET: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic word_writable(input logic [WORD_AW-1:0] w);
    case (w)
      WRD_IRQ_EN_SET, WRD_IRQ_EN_CLR, WRD_SWI_SET, WRD_SWI_CLR,
      WRD_FIQ_EN_SET, WRD_FIQ_EN_CLR: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/intc_access_decode.sv
module intc_access_decode
  import intc_pkg::*;
(
  input  logic               sel_i,
  input  logic               wr_i,
  input  logic [WORD_AW-1:0] word_i,
  input  logic               wbit0_i,
  output access_t            acc_o
);

  always_comb begin
    acc_o = '0;
    if (sel_i) begin
      if (wr_i) begin
        if (!word_writable(word_i)) begin
          acc_o.bad = 1'b1;
        end else begin
          case (word_i)
            WRD_IRQ_EN_SET: acc_o.en_set[PATH_IRQ] = 1'b1;
            WRD_IRQ_EN_CLR: acc_o.en_clr[PATH_IRQ] = 1'b1;
            WRD_FIQ_EN_SET: acc_o.en_set[PATH_FIQ] = 1'b1;
            WRD_FIQ_EN_CLR: acc_o.en_clr[PATH_FIQ] = 1'b1;
            WRD_SWI_SET:    acc_o.swi_set = wbit0_i;
            WRD_SWI_CLR:    acc_o.swi_clr = wbit0_i;
            default:        ;
          endcase
        end
      end else begin
        acc_o.rd_ok = word_readable(word_i);
        acc_o.bad   = !word_readable(word_i);
      end
    end
  end

endmodule

// File: rtl/intc_out_path.sv
module intc_out_path #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pending_i,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o,
  output logic         line_o
);

  function automatic logic [W-1:0] next_mask(input logic [W-1:0] cur,
                                             input logic set, input logic clr,
                                             input logic [W-1:0] d);
    if (set)      return cur | d;
    else if (clr) return cur & ~d;
    else          return cur;
  endfunction

  function automatic logic any_masked(input logic [W-1:0] p, input logic [W-1:0] m);
    return |(p & m);
  endfunction

  logic [W-1:0] mask_q;
  logic         line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= next_mask(mask_q, set_i, clr_i, wdata_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= 1'b0;
    else        line_q <= any_masked(pending_i, mask_q);
  end

  assign mask_o = mask_q;
  assign line_o = line_q;

endmodule

// File: rtl/intc_rsp_stage.sv
module intc_rsp_stage
  import intc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_i,
  input  access_t            acc_i,
  input  logic [WORD_AW-1:0] word_i,
  input  logic [W-1:0]       pending_i,
  input  logic [W-1:0]       irq_mask_i,
  input  logic [W-1:0]       fiq_mask_i,
  output logic [W-1:0]       rdata_o,
  output logic               rvalid_o,
  output logic               err_o
);

  function automatic logic [W-1:0] read_value(input logic [WORD_AW-1:0] w,
                                              input logic [W-1:0] p,
                                              input logic [W-1:0] im,
                                              input logic [W-1:0] fm);
    logic [W-1:0] v;
    v = '0;
    case (w)
      WRD_IRQ_STATUS: v = p & im;
      WRD_IRQ_RAW,
      WRD_FIQ_RAW:    v = p;
      WRD_IRQ_EN_SET: v = im;
      WRD_SWI_SET:    v[0] = p[0];
      WRD_FIQ_STATUS: v = p & fm;
      WRD_FIQ_EN_SET: v = fm;
      default:        v = '0;
    endcase
    return v;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      rdata_o  <= acc_i.rd_ok ? read_value(word_i, pending_i, irq_mask_i, fiq_mask_i) : '0;
      rvalid_o <= rd_i;
      err_o    <= acc_i.bad;
    end
  end

endmodule

// File: rtl/dual_level_intc.sv
module dual_level_intc
  import intc_pkg::*;
#(
  parameter int NSRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NSRC-1:0]    src_i,
  input  logic               bus_sel_i,
  input  logic               bus_wr_i,
  input  logic [WORD_AW-1:0] bus_word_i,
  input  logic [NSRC-1:0]    bus_wdata_i,
  output logic [NSRC-1:0]    bus_rdata_o,
  output logic               bus_rvalid_o,
  output logic               bus_err_o,
  output logic               irq_o,
  output logic               fiq_o
);

  access_t       acc;
  logic          swi_q;
  logic [NSRC-1:0] pending;
  logic [NSRC-1:0] mask_w [NPATH];
  logic [NPATH-1:0] line_w;

  // Named internal events for the checker
  logic [NSRC-1:0] irq_mask;
  logic [NSRC-1:0] fiq_mask;
  logic            irq_set_ev, irq_clr_ev, fiq_set_ev, fiq_clr_ev;

  intc_access_decode u_dec (
    .sel_i   (bus_sel_i),
    .wr_i    (bus_wr_i),
    .word_i  (bus_word_i),
    .wbit0_i (bus_wdata_i[0]),
    .acc_o   (acc)
  );

  // Software latch driving source 0
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           swi_q <= 1'b0;
    else if (acc.swi_set) swi_q <= 1'b1;
    else if (acc.swi_clr) swi_q <= 1'b0;
  end

  always_comb begin
    pending    = src_i;
    pending[0] = src_i[0] | swi_q;
  end

  for (genvar p = 0; p < NPATH; p++) begin : g_path
    intc_out_path #(.W(NSRC)) u_path (
      .clk       (clk),
      .rst_n     (rst_n),
      .pending_i (pending),
      .set_i     (acc.en_set[p]),
      .clr_i     (acc.en_clr[p]),
      .wdata_i   (bus_wdata_i),
      .mask_o    (mask_w[p]),
      .line_o    (line_w[p])
    );
  end

  assign irq_mask   = mask_w[PATH_IRQ];
  assign fiq_mask   = mask_w[PATH_FIQ];
  assign irq_set_ev = acc.en_set[PATH_IRQ];
  assign irq_clr_ev = acc.en_clr[PATH_IRQ];
  assign fiq_set_ev = acc.en_set[PATH_FIQ];
  assign fiq_clr_ev = acc.en_clr[PATH_FIQ];
  assign irq_o      = line_w[PATH_IRQ];
  assign fiq_o      = line_w[PATH_FIQ];

  intc_rsp_stage #(.W(NSRC)) u_rsp (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_i       (bus_sel_i & ~bus_wr_i),
    .acc_i      (acc),
    .word_i     (bus_word_i),
    .pending_i  (pending),
    .irq_mask_i (irq_mask),
    .fiq_mask_i (fiq_mask),
    .rdata_o    (bus_rdata_o),
    .rvalid_o   (bus_rvalid_o),
    .err_o      (bus_err_o)
  );

endmodule

// File: rtl/intc_checker.sv
module intc_checker
  import intc_pkg::*;
#(
  parameter int W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic [W-1:0]       src_i,
  input logic               bus_sel_i,
  input logic               bus_wr_i,
  input logic [WORD_AW-1:0] bus_word_i,
  input logic [W-1:0]       bus_wdata_i,
  input logic [W-1:0]       bus_rdata_o,
  input logic               bus_rvalid_o,
  input logic               bus_err_o,
  input logic               irq_o,
  input logic               fiq_o,
  input logic [W-1:0]       pending,
  input logic [W-1:0]       irq_mask,
  input logic [W-1:0]       fiq_mask,
  input logic               swi_q,
  input logic               irq_set_ev,
  input logic               irq_clr_ev,
  input logic               fiq_set_ev,
  input logic               fiq_clr_ev
);

  logic ro_write;
  assign ro_write = bus_sel_i && bus_wr_i &&
                    (bus_word_i == WRD_IRQ_STATUS || bus_word_i == WRD_IRQ_RAW ||
                     bus_word_i == WRD_FIQ_STATUS || bus_word_i == WRD_FIQ_RAW);

  assert_irq_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == $past(|(pending & irq_mask)));

  assert_fiq_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o == $past(|(pending & fiq_mask)));

  assert_irq_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(irq_set_ev) |-> ((irq_mask & $past(bus_wdata_i)) == $past(bus_wdata_i)));

  assert_irq_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(irq_clr_ev) |-> ((irq_mask & $past(bus_wdata_i)) == '0));

  assert_fiq_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fiq_set_ev) |-> ((fiq_mask & $past(bus_wdata_i)) == $past(bus_wdata_i)));

  assert_fiq_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fiq_clr_ev) |-> ((fiq_mask & $past(bus_wdata_i)) == '0));

  assert_level_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pending[W-1:1] == src_i[W-1:1]);

  assert_swi_or_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pending[0] == (src_i[0] | swi_q));

  assert_bad_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_err_o && bus_rvalid_o) |-> (bus_rdata_o == '0));

  assert_ro_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ro_write) |-> ($stable(irq_mask) && $stable(fiq_mask) && $stable(swi_q)));

  assert_err_after_access_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err_o |-> $past(bus_sel_i));

  assert_rvalid_after_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid_o == $past(bus_sel_i && !bus_wr_i));

endmodule

bind dual_level_intc intc_checker #(.W(NSRC)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .src_i        (src_i),
  .bus_sel_i    (bus_sel_i),
  .bus_wr_i     (bus_wr_i),
  .bus_word_i   (bus_word_i),
  .bus_wdata_i  (bus_wdata_i),
  .bus_rdata_o  (bus_rdata_o),
  .bus_rvalid_o (bus_rvalid_o),
  .bus_err_o    (bus_err_o),
  .irq_o        (irq_o),
  .fiq_o        (fiq_o),
  .pending      (pending),
  .irq_mask     (irq_mask),
  .fiq_mask     (fiq_mask),
  .swi_q        (swi_q),
  .irq_set_ev   (irq_set_ev),
  .irq_clr_ev   (irq_clr_ev),
  .fiq_set_ev   (fiq_set_ev),
  .fiq_clr_ev   (fiq_clr_ev)
);

// File: tb/test_dual_level_intc.sv
module test_dual_level_intc;

  localparam int CLK_PERIOD = 10;
  localparam int NSRC       = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] src_i = '0;
  logic            bus_sel_i = 1'b0;
  logic            bus_wr_i = 1'b0;
  logic [3:0]      bus_word_i = '0;
  logic [NSRC-1:0] bus_wdata_i = '0;
  logic [NSRC-1:0] bus_rdata_o;
  logic            bus_rvalid_o, bus_err_o, irq_o, fiq_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_level_intc #(.NSRC(NSRC)) i_dual_level_intc (
    .clk(clk), .rst_n(rst_n), .src_i(src_i),
    .bus_sel_i(bus_sel_i), .bus_wr_i(bus_wr_i), .bus_word_i(bus_word_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
    .bus_rvalid_o(bus_rvalid_o), .bus_err_o(bus_err_o),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  // Access is taken at the rising edge between the two falling edges
  task automatic bus_write(input logic [3:0] w, input logic [31:0] d, output logic err);
    @(negedge clk);
    bus_sel_i = 1'b1; bus_wr_i = 1'b1; bus_word_i = w; bus_wdata_i = d;
    @(negedge clk);
    bus_sel_i = 1'b0; bus_wr_i = 1'b0; bus_wdata_i = '0;
    err = bus_err_o;
  endtask

  task automatic bus_read(input logic [3:0] w, output logic [31:0] d,
                          output logic err, output logic vld);
    @(negedge clk);
    bus_sel_i = 1'b1; bus_wr_i = 1'b0; bus_word_i = w;
    @(negedge clk);
    bus_sel_i = 1'b0;
    d = bus_rdata_o; err = bus_err_o; vld = bus_rvalid_o;
  endtask

  task automatic expect_read(input string req, input logic [3:0] w, input logic [31:0] exp);
    logic [31:0] d; logic e, v;
    bus_read(w, d, e, v);
    check(req, $sformatf("read word %0d", w), d, exp);
    check(req, $sformatf("read word %0d err", w), {31'b0, e}, 32'd0);
    check(req, $sformatf("read word %0d valid", w), {31'b0, v}, 32'd1);
  endtask

  task automatic t_reset;
    src_i = '1;
    repeat (3) @(negedge clk);
    check("R1", "irq during reset", {31'b0, irq_o}, 0);
    check("R1", "fiq during reset", {31'b0, fiq_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", "irq after reset", {31'b0, irq_o}, 0);
    check("R1", "fiq after reset", {31'b0, fiq_o}, 0);
    check("R1", "err after reset", {31'b0, bus_err_o}, 0);
    expect_read("R1", 4'd2, 32'h0);
    expect_read("R1", 4'd10, 32'h0);
    expect_read("R5", 4'd1, 32'hFFFF_FFFF);
    src_i = '0;
    expect_read("R1", 4'd4, 32'h0);
  endtask

  task automatic t_irq_path;
    logic e;
    src_i = 32'h0000_0100;
    bus_write(4'd2, 32'h0000_0100, e);
    check("R4", "set err", {31'b0, e}, 0);
    check("R2", "irq one edge before due", {31'b0, irq_o}, 0);
    @(negedge clk);
    check("R2", "irq due", {31'b0, irq_o}, 1);
    check("R3", "fiq unaffected by irq mask", {31'b0, fiq_o}, 0);
    src_i = '0;
    check("R6", "irq before line drop seen", {31'b0, irq_o}, 1);
    @(negedge clk);
    check("R6", "irq after line drop", {31'b0, irq_o}, 0);
  endtask

  task automatic t_fiq_path;
    logic e;
    bus_write(4'd10, 32'h8000_0001, e);
    src_i = 32'h8000_0000;
    check("R3", "fiq before edge", {31'b0, fiq_o}, 0);
    @(negedge clk);
    check("R3", "fiq due", {31'b0, fiq_o}, 1);
    check("R2", "irq unaffected by fiq mask", {31'b0, irq_o}, 0);
    src_i = '0;
    @(negedge clk);
    check("R6", "fiq after line drop", {31'b0, fiq_o}, 0);
  endtask

  task automatic t_enable;
    logic e;
    bus_write(4'd2, 32'h0000_00F0, e);
    expect_read("R4", 4'd2, 32'h0000_01F0);
    bus_write(4'd3, 32'h0000_0110, e);
    expect_read("R4", 4'd2, 32'h0000_00E0);
    expect_read("R4", 4'd10, 32'h8000_0001);
    bus_write(4'd11, 32'hFFFF_FFFF, e);
    check("R4", "clear err", {31'b0, e}, 0);
    expect_read("R4", 4'd10, 32'h0);
    expect_read("R4", 4'd2, 32'h0000_00E0);
  endtask

  task automatic t_status;
    logic e;
    src_i = 32'h0000_00A5;
    bus_write(4'd10, 32'h0000_000F, e);
    expect_read("R5", 4'd0, 32'h0000_00A0);
    expect_read("R5", 4'd1, 32'h0000_00A5);
    expect_read("R5", 4'd8, 32'h0000_0005);
    expect_read("R5", 4'd9, 32'h0000_00A5);
    check("R2", "irq with masked pending", {31'b0, irq_o}, 1);
    src_i = 32'h0000_0005;
    @(negedge clk);
    check("R2", "irq with only unmasked pending", {31'b0, irq_o}, 0);
    check("R3", "fiq with masked pending", {31'b0, fiq_o}, 1);
    src_i = '0;
    @(negedge clk);
  endtask

  task automatic t_soft;
    logic e;
    bus_write(4'd3, 32'hFFFF_FFFF, e);
    bus_write(4'd2, 32'h0000_0001, e);
    bus_write(4'd4, 32'hFFFF_FFFE, e);
    expect_read("R7", 4'd4, 32'h0);
    check("R7", "irq with latch clear", {31'b0, irq_o}, 0);
    bus_write(4'd4, 32'h0000_0001, e);
    check("R7", "irq not before due edge", {31'b0, irq_o}, 0);
    @(negedge clk);
    check("R7", "irq from software latch", {31'b0, irq_o}, 1);
    expect_read("R7", 4'd4, 32'h1);
    expect_read("R7", 4'd1, 32'h1);
    bus_write(4'd5, 32'hFFFF_FFFE, e);
    expect_read("R7", 4'd4, 32'h1);
    bus_write(4'd5, 32'h0000_0001, e);
    expect_read("R7", 4'd4, 32'h0);
    check("R7", "irq after latch clear", {31'b0, irq_o}, 0);
    src_i = 32'h0000_0001;
    expect_read("R7", 4'd4, 32'h1);
    src_i = '0;
    expect_read("R7", 4'd4, 32'h0);
  endtask

  task automatic t_bad_reads;
    logic [31:0] d; logic e, v;
    logic [3:0] bad_words [5] = '{4'd3, 4'd5, 4'd11, 4'd6, 4'd15};
    src_i = 32'hFFFF_FFFF;
    for (int i = 0; i < 5; i++) begin
      bus_read(bad_words[i], d, e, v);
      check("R8", $sformatf("bad read word %0d data", bad_words[i]), d, 32'h0);
      check("R8", $sformatf("bad read word %0d err", bad_words[i]), {31'b0, e}, 1);
      check("R10", $sformatf("bad read word %0d valid", bad_words[i]), {31'b0, v}, 1);
    end
    src_i = '0;
  endtask

  task automatic t_bad_writes;
    logic e;
    logic [3:0] ro_words [5] = '{4'd0, 4'd1, 4'd8, 4'd9, 4'd7};
    for (int i = 0; i < 5; i++) begin
      bus_write(ro_words[i], 32'hFFFF_FFFF, e);
      check("R9", $sformatf("write word %0d err", ro_words[i]), {31'b0, e}, 1);
    end
    expect_read("R9", 4'd2, 32'h0000_0001);
    expect_read("R9", 4'd10, 32'h0000_000F);
    expect_read("R9", 4'd4, 32'h0);
  endtask

  task automatic t_err_pulse;
    logic [31:0] d; logic e, v;
    bus_read(4'd3, d, e, v);
    check("R10", "err in due cycle", {31'b0, e}, 1);
    @(negedge clk);
    check("R10", "err one cycle later", {31'b0, bus_err_o}, 0);
    check("R10", "valid drops when idle", {31'b0, bus_rvalid_o}, 0);
    bus_read(4'd2, d, e, v);
    check("R10", "err after legal read", {31'b0, e}, 0);
    bus_write(4'd4, 32'h0, e);
    check("R10", "err after legal write", {31'b0, e}, 0);
  endtask

  initial begin
    t_reset();
    t_irq_path();
    t_fiq_path();
    t_enable();
    t_status();
    t_soft();
    t_bad_reads();
    t_bad_writes();
    t_err_pulse();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule